// File: doc/BRIEF.md
# Clock Start-Up and Low-Power Sequencer

This block turns a free-running oscillator clock into the bus-rate clock enables for the processor and for the peripherals. It also decides when those enables may run. An internal divider produces a reference tick at half the oscillator rate and a bus strobe at one quarter of it. One down-counter, clocked by the reference tick, serves two timeouts: the start-up delay after a power or supply-drop reset, and the recovery delay on leaving stop mode.

After a reset request, both enables stay off and the reset pin is driven low until the counter has seen 4096 reference ticks. The bus then starts at once. Stop mode turns off both enables. An interrupt or break wakes the block from stop and starts a recovery delay of either 4096 or 32 reference ticks. The choice of length is captured when stop is entered. Wait mode turns off only the processor enable. An interrupt or break ends wait within one bus cycle and needs no timeout. A reset request in any state starts the full start-up sequence again.

Top module: `clkseq_ctrl`

## Requirements
- R1: In run mode, `cpu_ck_en` and `per_ck_en` are each high for exactly one oscillator cycle in every four.
- R2: While the block's own reset is applied, `rst_pin_n`, `cpu_ck_en` and `per_ck_en` are low and `cnt_busy` is high. After release, `rst_pin_n` stays low for about 8192 oscillator cycles (4096 reference ticks).
- R3: At the end of a start-up timeout, `rst_pin_n` rises and the first enable strobes appear in the very next bus cycle, 4 oscillator cycles later counting the edge where the pin rises.
- R4: A `stop_req` seen at a bus boundary in run mode stops both enables, and `cnt_busy` stays low until a wake source arrives.
- R5: In stop, `wake_irq` or `wake_brk` loads the recovery delay. `cnt_busy` is then high for exactly 64 oscillator cycles when the captured select is 1, or 8192 when it is 0. Both enables stay off during the delay and resume in the bus cycle after it.
- R6: The `short_dly` value is captured at stop entry. Changes made to it after entry do not affect the recovery length.
- R7: A `wait_req` seen at a bus boundary in run mode stops `cpu_ck_en` while `per_ck_en` keeps strobing, and `cnt_busy` stays low.
- R8: In wait, `wake_irq` or `wake_brk` brings back `cpu_ck_en` within 8 oscillator cycles, and `cnt_busy` stays low.
- R9: A `por_req` seen at one bus boundary during stop recovery or wait drives `rst_pin_n` low for exactly 8192 oscillator cycles and turns off both enables.
- R10: The internal clock-on states of the enables change only at bus boundaries, so strobes are always spaced by a multiple of four oscillator cycles.
- R11: In run mode, `wake_irq` and `wake_brk` have no effect: the strobes continue and `cnt_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| por_req | input | 1 | Power-on or low-voltage reset request, sampled at bus boundaries |
| stop_req | input | 1 | Enter stop request from the processor |
| wait_req | input | 1 | Enter wait request from the processor |
| wake_irq | input | 1 | Interrupt wake source |
| wake_brk | input | 1 | Break wake source |
| short_dly | input | 1 | Recovery length select: 1 selects 32 ticks, 0 selects 4096 ticks |
| cpu_ck_en | output | 1 | Processor bus-clock enable strobe |
| per_ck_en | output | 1 | Peripheral bus-clock enable strobe |
| rst_pin_n | output | 1 | Active-low reset pin drive |
| cnt_busy | output | 1 | Timeout counter is running |

## Verification
The hardest cases to reach from the ports are a reset request that lands during stop recovery, and one that lands during wait. In both, no processor strobe is available to show the divider phase. The bench uses two different references to find a bus boundary. In recovery, it counts oscillator cycles from the rising edge of `cnt_busy`, which is always set at a boundary. In wait, it aligns to the peripheral strobe, which keeps running. It then holds `por_req` over exactly one boundary, so the expected 8192-cycle pin pulse is exact and not just a range.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int DIV_W = 2;
  typedef enum logic [2:0] {
    SQ_POR   = 3'd0,
    SQ_RUN   = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_STOP  = 3'd3,
    SQ_RECOV = 3'd4
  } seq_state_e;
endpackage

// File: rtl/clkseq_rstsync.sv
module clkseq_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/clkseq_div.sv
module clkseq_div
  import clkseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic iclk_tick,
  output logic bus_tick
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // reference tick at half the oscillator rate, bus boundary at a quarter
  assign iclk_tick = div_q[0];
  assign bus_tick  = &div_q;

  assert_iclk_alternates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    iclk_tick |=> !iclk_tick);
endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
  parameter int POR_CYC   = 4096,
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iclk_tick,
  input  logic ld_por,
  input  logic ld_rec,
  input  logic sel_short,
  output logic busy,
  output logic fin
);
  localparam int MAX_A = (POR_CYC > LONG_CYC) ? POR_CYC : LONG_CYC;
  localparam int MAX_C = (MAX_A > SHORT_CYC) ? MAX_A : SHORT_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] POR_V   = CNT_W'(POR_CYC);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_por)                     cnt_d = POR_V;
    else if (ld_rec)                cnt_d = sel_short ? SHORT_V : LONG_V;
    else if (iclk_tick && busy)     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= POR_V;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  // finished now, or finishing on this very tick
  assign fin  = !busy || (cnt_q == CNT_W'(1) && iclk_tick);

  assert_busy_ends_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(iclk_tick));
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic fin,
  input  logic por_req,
  input  logic stop_req,
  input  logic wait_req,
  input  logic wake,
  input  logic short_dly,
  output logic ld_por,
  output logic ld_rec,
  output logic sel_short,
  output logic cpu_on,
  output logic per_on,
  output logic rst_pin_n
);
  seq_state_e st_q, st_d;
  logic cpu_d, per_d, sel_d;

  always_comb begin
    st_d   = st_q;
    cpu_d  = cpu_on;
    per_d  = per_on;
    sel_d  = sel_short;
    ld_por = 1'b0;
    ld_rec = 1'b0;
    if (bus_tick) begin
      if (por_req) begin
        st_d   = SQ_POR;
        ld_por = 1'b1;
        cpu_d  = 1'b0;
        per_d  = 1'b0;
      end else begin
        unique case (st_q)
          SQ_POR: if (fin) begin
            st_d  = SQ_RUN;
            cpu_d = 1'b1;
            per_d = 1'b1;
          end
          SQ_RUN: if (stop_req) begin
            st_d  = SQ_STOP;
            cpu_d = 1'b0;
            per_d = 1'b0;
            sel_d = short_dly;
          end else if (wait_req) begin
            st_d  = SQ_WAIT;
            cpu_d = 1'b0;
          end
          SQ_WAIT: if (wake) begin
            st_d  = SQ_RUN;
            cpu_d = 1'b1;
          end
          SQ_STOP: if (wake) begin
            st_d   = SQ_RECOV;
            ld_rec = 1'b1;
          end
          SQ_RECOV: if (fin) begin
            st_d  = SQ_RUN;
            cpu_d = 1'b1;
            per_d = 1'b1;
          end
          default: st_d = SQ_POR;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_POR;
      cpu_on    <= 1'b0;
      per_on    <= 1'b0;
      sel_short <= 1'b0;
    end else begin
      st_q      <= st_d;
      cpu_on    <= cpu_d;
      per_on    <= per_d;
      sel_short <= sel_d;
    end
  end

  assign rst_pin_n = (st_q != SQ_POR);

  assert_pin_gates_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |-> (!cpu_on && !per_on));
  assert_cpu_needs_per_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_on |-> per_on);
  assert_cpu_edge_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_on != $past(cpu_on)) |-> $past(bus_tick));
  assert_per_edge_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (per_on != $past(per_on)) |-> $past(bus_tick));
  assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_RUN) |=> $stable(sel_short));
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl #(
  parameter int POR_CYC   = 4096,
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic por_req,
  input  logic stop_req,
  input  logic wait_req,
  input  logic wake_irq,
  input  logic wake_brk,
  input  logic short_dly,
  output logic cpu_ck_en,
  output logic per_ck_en,
  output logic rst_pin_n,
  output logic cnt_busy
);
  logic srst_n, iclk_tick, bus_tick;
  logic fin, ld_por, ld_rec, sel_short, cpu_on, per_on;

  clkseq_rstsync u_sync (
    .clk(osc_clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  clkseq_div u_div (
    .clk(osc_clk), .rst_n(srst_n), .iclk_tick(iclk_tick), .bus_tick(bus_tick)
  );

  clkseq_timer #(
    .POR_CYC(POR_CYC), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
  ) u_timer (
    .clk(osc_clk), .rst_n(srst_n), .iclk_tick(iclk_tick),
    .ld_por(ld_por), .ld_rec(ld_rec), .sel_short(sel_short),
    .busy(cnt_busy), .fin(fin)
  );

  clkseq_fsm u_fsm (
    .clk(osc_clk), .rst_n(srst_n), .bus_tick(bus_tick), .fin(fin),
    .por_req(por_req), .stop_req(stop_req), .wait_req(wait_req),
    .wake(wake_irq | wake_brk), .short_dly(short_dly),
    .ld_por(ld_por), .ld_rec(ld_rec), .sel_short(sel_short),
    .cpu_on(cpu_on), .per_on(per_on), .rst_pin_n(rst_pin_n)
  );

  assign cpu_ck_en = cpu_on & bus_tick;
  assign per_ck_en = per_on & bus_tick;

  assert_cpu_strobe_on_boundary_R1: assert property (@(posedge osc_clk) disable iff (!srst_n)
    cpu_ck_en |=> !cpu_ck_en);
endmodule

// File: tb/sim_clkseq_ctrl.sv
module sim_clkseq_ctrl;
  logic osc_clk = 1'b0;
  logic rst_n, por_req, stop_req, wait_req, wake_irq, wake_brk, short_dly;
  logic cpu_ck_en, per_ck_en, rst_pin_n, cnt_busy;
  int nchk = 0;
  int nbad = 0;

  always #2.5 osc_clk = ~osc_clk;

  clkseq_ctrl u0 (
    .osc_clk(osc_clk), .rst_n(rst_n), .por_req(por_req), .stop_req(stop_req),
    .wait_req(wait_req), .wake_irq(wake_irq), .wake_brk(wake_brk),
    .short_dly(short_dly), .cpu_ck_en(cpu_ck_en), .per_ck_en(per_ck_en),
    .rst_pin_n(rst_pin_n), .cnt_busy(cnt_busy)
  );

  // {select at entry, select after entry, source 1=break, expected busy cycles}
  localparam logic [16:0] VEC [0:3] = '{
    {1'b1, 1'b1, 1'b0, 14'd64},
    {1'b1, 1'b0, 1'b1, 14'd64},
    {1'b0, 1'b1, 1'b0, 14'd8192},
    {1'b0, 1'b0, 1'b1, 14'd8192}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic align_cpu();
    int g = 0;
    while (!cpu_ck_en && g < 64) begin g++; @(negedge osc_clk); end
  endtask

  task automatic gap_to_cpu(output int k);
    k = 1;
    while (!cpu_ck_en && k < 64) begin k++; @(negedge osc_clk); end
  endtask

  initial begin
    #750000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int n, k, c, p, b;
    rst_n = 0; por_req = 0; stop_req = 0; wait_req = 0;
    wake_irq = 0; wake_brk = 0; short_dly = 0;
    tick(3);
    // R2 reset state
    c = 0;
    for (int i = 0; i < 8; i++) begin
      if (cpu_ck_en || per_ck_en || rst_pin_n || !cnt_busy) c++;
      tick(1);
    end
    check(c == 0, "R2 reset outputs", c, 0);
    rst_n = 1;
    n = 0;
    while (!rst_pin_n && n < 9000) begin n++; tick(1); end
    check(n >= 8192 && n <= 8196, "R2 start-up pin low", n, 8192);
    gap_to_cpu(k);
    check(k == 4, "R3 first strobe after timeout", k, 4);
    check(per_ck_en == 1'b1, "R3 peripheral strobe", per_ck_en, 1);

    // R1 / R10 strobe spacing in run
    c = 0;
    for (int i = 1; i <= 20; i++) begin
      tick(1);
      if (cpu_ck_en != (i % 4 == 0) || per_ck_en != cpu_ck_en) c++;
    end
    check(c == 0, "R1 R10 strobe spacing", c, 0);

    // R11 wake sources ignored in run
    align_cpu();
    wake_irq = 1; wake_brk = 1;
    c = 0; b = 0;
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      if (cpu_ck_en) c++;
      if (cnt_busy) b++;
    end
    wake_irq = 0; wake_brk = 0;
    check(c == 2, "R11 strobes continue", c, 2);
    check(b == 0, "R11 counter idle", b, 0);

    // stop / recovery vectors: R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      align_cpu();
      short_dly = VEC[v][16];
      stop_req = 1;
      tick(4);
      stop_req = 0;
      short_dly = VEC[v][15];
      c = 0; b = 0;
      for (int i = 0; i < 12; i++) begin
        if (cpu_ck_en || per_ck_en) c++;
        if (cnt_busy) b++;
        tick(1);
      end
      check(c == 0 && b == 0, "R4 stop gates clocks", c + b, 0);
      if (VEC[v][14]) wake_brk = 1; else wake_irq = 1;
      k = 0;
      while (!cnt_busy && k < 8) begin k++; tick(1); end
      wake_irq = 0; wake_brk = 0;
      n = 0; c = 0;
      while (cnt_busy && n < 9000) begin
        n++;
        if (cpu_ck_en || per_ck_en) c++;
        tick(1);
      end
      check(n == int'(VEC[v][13:0]), "R5 R6 recovery length", n, int'(VEC[v][13:0]));
      check(c == 0, "R5 clocks off in recovery", c, 0);
      gap_to_cpu(k);
      check(k == 4 && per_ck_en, "R5 clocks resume", k, 4);
    end

    // wait mode: R7 R8, once per wake source
    for (int s = 0; s < 2; s++) begin
      align_cpu();
      wait_req = 1;
      tick(4);
      wait_req = 0;
      c = 0; p = 0; b = 0;
      for (int i = 0; i < 12; i++) begin
        tick(1);
        if (cpu_ck_en) c++;
        if (per_ck_en) p++;
        if (cnt_busy) b++;
      end
      check(c == 0, "R7 cpu gated in wait", c, 0);
      check(p == 3, "R7 peripheral runs in wait", p, 3);
      check(b == 0, "R7 counter idle in wait", b, 0);
      if (s == 1) wake_brk = 1; else wake_irq = 1;
      k = 0; b = 0;
      while (!cpu_ck_en && k < 16) begin
        k++;
        if (cnt_busy) b++;
        if (k == 4) begin wake_irq = 0; wake_brk = 0; end
        tick(1);
      end
      wake_irq = 0; wake_brk = 0;
      check(k <= 8, "R8 cpu back from wait", k, 8);
      check(b == 0, "R8 no timeout on wait exit", b, 0);
    end

    // R9 reset during stop recovery
    align_cpu();
    short_dly = 0;
    stop_req = 1;
    tick(4);
    stop_req = 0;
    tick(4);
    wake_irq = 1;
    k = 0;
    while (!cnt_busy && k < 8) begin k++; tick(1); end
    wake_irq = 0;
    tick(399);
    por_req = 1;
    tick(1);
    check(rst_pin_n == 1'b0, "R9 pin falls in recovery", rst_pin_n, 0);
    n = 0;
    while (!rst_pin_n && n < 9000) begin
      n++;
      if (n == 4) por_req = 0;
      tick(1);
    end
    check(n == 8192, "R9 full timeout after recovery abort", n, 8192);
    gap_to_cpu(k);
    check(k == 4, "R9 R3 restart after recovery abort", k, 4);

    // R9 reset during wait
    align_cpu();
    wait_req = 1;
    tick(4);
    wait_req = 0;
    k = 0;
    while (!per_ck_en && k < 8) begin k++; tick(1); end
    por_req = 1;
    tick(1);
    check(rst_pin_n == 1'b0 && per_ck_en == 1'b0, "R9 pin falls in wait", rst_pin_n, 0);
    n = 0;
    while (!rst_pin_n && n < 9000) begin
      n++;
      if (n == 4) por_req = 0;
      tick(1);
    end
    check(n == 8192, "R9 full timeout after wait abort", n, 8192);
    gap_to_cpu(k);
    check(k == 4, "R9 R3 restart after wait abort", k, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule